// File: doc/BRIEF.md
# ADC Conversion Autosequencer

This controller runs a list of conversions on a single shared 12-bit analog-to-digital converter. Sixteen slots each hold a 4-bit analog channel number. The slots are split into two sequencers of eight slots each, or joined into one sixteen-slot sequencer. A software strobe or one of two event inputs starts a run. The controller then drives the channel multiplexer select for each slot and holds the sample window open for a programmable number of cycles. It hands the conversion to the converter with a start pulse, and waits for the done strobe.

Each returned code goes into the result register that belongs to its slot. At the end of each run the controller either sends the slot pointer back to slot 0 (continuous mode) or keeps it on the next slot (start/stop mode), so that a later trigger carries on through the list. It then pulses an end-of-sequence interrupt, on every run or on every second run. A trigger that arrives while its sequencer is busy is held as one pending request. A further trigger in that state sets a sticky overflow flag.

Top module: `adc_autoseq`

## Requirements
- R1: In dual mode (`cascade`=0), sequencer 1 owns slots 0-7 and sequencer 2 owns slots 8-15. A run of sequencer 1 converts `last_slot1[2:0]`+1 slots and a run of sequencer 2 converts `last_slot2`+1 slots, in rising order from the sequencer's slot pointer. For each slot, `mux_sel` carries `slot_chan[slot*4 +: 4]`.
- R2: In cascade mode (`cascade`=1), one sequencer owns slots 0-15 and converts `last_slot1`+1 slots per run. It is started by `sw_start[0]`, `ev_a` or `ev_b`, and `sw_start[1]` has no effect.
- R3: In dual mode, sequencer 1 is started by `sw_start[0]` or `ev_a`, and sequencer 2 is started by `sw_start[1]` or `ev_b`.
- R4: Only one conversion is in progress at a time. When both sequencers are waiting, sequencer 1 goes first. A run, once started, completes before the other sequencer starts.
- R5: Each code returned on `conv_data` with `conv_done` is stored in `results[slot*12 +: 12]` for the slot being converted. All other result registers keep their values.
- R6: For each conversion, `sample_hold` stays high for `acq_len`+1 cycles, with `mux_sel` stable over that time. `conv_start` is high only in the last of those cycles. The next slot starts only after `conv_done`.
- R7: In continuous mode (`stop_start[s]`=0), the slot pointer of sequencer s returns to 0 after each end of sequence.
- R8: In start/stop mode (`stop_start[s]`=1), the next run starts at the slot after the last one converted. The pointer wraps within the sequencer's own slot range: 8 slots in dual mode, 16 in cascade mode.
- R9: A `seq_clear[s]` pulse while sequencer s is not running sets its pointer to 0 and clears its pending request, its overflow flag and its interrupt phase.
- R10: With `irq_alt[s]`=0, `irq[s]` pulses for one cycle at every end of sequence. With `irq_alt[s]`=1, it pulses only on every second end of sequence.
- R11: A trigger that arrives while a request for that sequencer is already pending sets `ovf[s]`. A trigger that arrives while the sequencer is running and has no pending request is queued and runs next. `ovf[s]` stays set until `seq_clear[s]`.
- R12: After reset, all results are 0, and `busy`, `irq`, `ovf`, `conv_start` and `sample_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cascade | input | 1 | 1: one 16-slot sequencer; 0: two 8-slot sequencers |
| stop_start | input | 2 | Per sequencer: 1 = start/stop mode, 0 = continuous |
| irq_alt | input | 2 | Per sequencer: 1 = interrupt on every second end of sequence |
| last_slot1 | input | 4 | Conversions per run minus one, sequencer 1 (low 3 bits in dual mode) |
| last_slot2 | input | 3 | Conversions per run minus one, sequencer 2 |
| slot_chan | input | 64 | 4-bit channel number per slot, slot n at bits n*4 +: 4 |
| acq_len | input | 4 | Sample window length minus one, in cycles |
| sw_start | input | 2 | Software start strobes, one per sequencer |
| ev_a | input | 1 | Event trigger A |
| ev_b | input | 1 | Event trigger B |
| seq_clear | input | 2 | Per-sequencer pointer and flag reset |
| conv_start | output | 1 | Start pulse to the converter |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter result code |
| mux_sel | output | 4 | Analog channel select |
| sample_hold | output | 1 | High during the sample window |
| results | output | 192 | Result registers, slot n at bits n*12 +: 12 |
| irq | output | 2 | End-of-sequence interrupt pulses |
| ovf | output | 2 | Sticky trigger overflow flags |
| busy | output | 2 | Sequencer running or request pending |

## Verification
A wrong slot pointer shows up at once as a wrong channel on `mux_sel` at the first conversion of the next run, and a slot-offset error also puts the returned code in the wrong field of `results` by the end of that run. A wrong arbitration or queuing state shows up as a changed order of channels across two runs, or as a missing second run. A wrong interrupt phase shows up as a missing or extra `irq` pulse at the next end of sequence, and a wrong window counter shows up as a wrong count of `sample_hold` cycles in the first conversion. The bench sweeps every run length in both modes and every window length, and predicts each channel and code from the slot arithmetic.

// File: rtl/adc_autoseq.sv
module adc_autoseq #(
  parameter int SLOTS_PER_SEQ = 8,
  parameter int CH_W          = 4,
  parameter int DATA_W        = 12,
  parameter int ACQ_W         = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cascade,
  input  logic [1:0]                stop_start,
  input  logic [1:0]                irq_alt,
  input  logic [$clog2(2*SLOTS_PER_SEQ)-1:0] last_slot1,
  input  logic [$clog2(SLOTS_PER_SEQ)-1:0]   last_slot2,
  input  logic [2*SLOTS_PER_SEQ*CH_W-1:0]    slot_chan,
  input  logic [ACQ_W-1:0]          acq_len,
  input  logic [1:0]                sw_start,
  input  logic                      ev_a,
  input  logic                      ev_b,
  input  logic [1:0]                seq_clear,
  output logic                      conv_start,
  input  logic                      conv_done,
  input  logic [DATA_W-1:0]         conv_data,
  output logic [CH_W-1:0]           mux_sel,
  output logic                      sample_hold,
  output logic [2*SLOTS_PER_SEQ*DATA_W-1:0]  results,
  output logic [1:0]                irq,
  output logic [1:0]                ovf,
  output logic [1:0]                busy
);
  localparam int SLOTS  = 2 * SLOTS_PER_SEQ;
  localparam int HALF_W = $clog2(SLOTS_PER_SEQ);
  localparam int PTR_W  = HALF_W + 1;

  typedef enum logic [1:0] {IDLE, ACQ, CONV} st_t;

  st_t               st;
  logic              cur;
  logic [PTR_W-1:0]  ptr0, rptr, cnt;
  logic [HALF_W-1:0] ptr1;
  logic [ACQ_W-1:0]  acq_cnt;
  logic [1:0]        req, ovf_q, irq_q, half_q;
  logic [DATA_W-1:0] res [SLOTS];

  logic [1:0]       trig;
  logic [PTR_W-1:0] slot, last, rnext_raw, rnext;
  logic             wide;

  assign trig[0]   = sw_start[0] | ev_a | (cascade & ev_b);
  assign trig[1]   = ~cascade & (sw_start[1] | ev_b);
  assign wide      = cascade & ~cur;
  assign slot      = cur ? {1'b1, rptr[HALF_W-1:0]} : rptr;
  assign last      = cur ? {1'b0, last_slot2}
                   : (cascade ? last_slot1 : {1'b0, last_slot1[HALF_W-1:0]});
  assign rnext_raw = rptr + 1'b1;
  assign rnext     = wide ? rnext_raw : {1'b0, rnext_raw[HALF_W-1:0]};

  assign mux_sel     = slot_chan[slot*CH_W +: CH_W];
  assign sample_hold = (st == ACQ);
  assign conv_start  = (st == ACQ) && (acq_cnt == acq_len);
  assign irq         = irq_q;
  assign ovf         = ovf_q;
  assign busy[0]     = req[0] | ((st != IDLE) & ~cur);
  assign busy[1]     = req[1] | ((st != IDLE) &  cur);

  for (genvar g = 0; g < SLOTS; g++) begin : g_res
    assign results[g*DATA_W +: DATA_W] = res[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cur <= 1'b0;
      ptr0 <= '0; ptr1 <= '0; rptr <= '0; cnt <= '0; acq_cnt <= '0;
      req <= '0; ovf_q <= '0; irq_q <= '0; half_q <= '0;
      for (int i = 0; i < SLOTS; i++) res[i] <= '0;
    end else begin
      irq_q <= '0;
      for (int s = 0; s < 2; s++)
        if (trig[s]) begin
          if (req[s]) ovf_q[s] <= 1'b1;
          else        req[s]   <= 1'b1;
        end
      case (st)
        IDLE: if (req[0] || req[1]) begin
          st <= ACQ; cnt <= '0; acq_cnt <= '0;
          cur <= ~req[0];
          if (req[0]) begin
            rptr <= cascade ? ptr0 : {1'b0, ptr0[HALF_W-1:0]};
            req[0] <= trig[0]; ovf_q[0] <= ovf_q[0];
          end else begin
            rptr <= {1'b0, ptr1};
            req[1] <= trig[1]; ovf_q[1] <= ovf_q[1];
          end
        end
        ACQ: begin
          if (acq_cnt == acq_len) st <= CONV;
          else acq_cnt <= acq_cnt + 1'b1;
        end
        CONV: if (conv_done) begin
          res[slot] <= conv_data;
          if (cnt == last) begin
            st <= IDLE;
            if (cur) ptr1 <= stop_start[1] ? rnext[HALF_W-1:0] : '0;
            else     ptr0 <= stop_start[0] ? rnext : '0;
            if (irq_alt[cur]) begin
              irq_q[cur]  <= half_q[cur];
              half_q[cur] <= ~half_q[cur];
            end else begin
              irq_q[cur]  <= 1'b1;
              half_q[cur] <= 1'b0;
            end
          end else begin
            st <= ACQ; acq_cnt <= '0;
            cnt <= cnt + 1'b1; rptr <= rnext;
          end
        end
        default: st <= IDLE;
      endcase
      if (seq_clear[0] && !((st != IDLE) && !cur)) begin
        ptr0 <= '0; req[0] <= 1'b0; ovf_q[0] <= 1'b0; half_q[0] <= 1'b0;
      end
      if (seq_clear[1] && !((st != IDLE) && cur)) begin
        ptr1 <= '0; req[1] <= 1'b0; ovf_q[1] <= 1'b0; half_q[1] <= 1'b0;
      end
    end
  end

  assert_single_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_mux_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_hold && $past(sample_hold)) |-> $stable(mux_sel));
  assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));
  assert_irq_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != 2'b00) |-> $past(conv_done));
  assert_ovf_sticky0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !seq_clear[0]) |=> ovf[0]);
  assert_ovf_sticky1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[1] && !seq_clear[1]) |=> ovf[1]);
  assert_ovf_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[0]) |-> $past(busy[0]));
endmodule

// File: tb/adc_autoseq_tb.sv
module adc_autoseq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cascade = 1'b0;
  logic [1:0]  stop_start = '0, irq_alt = '0, sw_start = '0, seq_clear = '0;
  logic [3:0]  last_slot1 = '0, acq_len = 4'd1;
  logic [2:0]  last_slot2 = '0;
  logic [63:0] slot_chan;
  logic        ev_a = 1'b0, ev_b = 1'b0, conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        conv_start, sample_hold;
  logic [3:0]  mux_sel;
  logic [191:0] results;
  logic [1:0]  irq, ovf, busy;

  adc_autoseq dut_i (
    .clk(clk), .rst_n(rst_n), .cascade(cascade), .stop_start(stop_start),
    .irq_alt(irq_alt), .last_slot1(last_slot1), .last_slot2(last_slot2),
    .slot_chan(slot_chan), .acq_len(acq_len), .sw_start(sw_start),
    .ev_a(ev_a), .ev_b(ev_b), .seq_clear(seq_clear), .conv_start(conv_start),
    .conv_done(conv_done), .conv_data(conv_data), .mux_sel(mux_sel),
    .sample_hold(sample_hold), .results(results), .irq(irq), .ovf(ovf),
    .busy(busy));

  int n_cmp = 0, n_bad = 0;
  int obs[$];
  int sh_run = 0, icnt0 = 0, icnt1 = 0, lat = 2;
  logic [7:0]  tag = 8'h00;
  logic [11:0] exp_res [16];

  function automatic int chan(input int s);
    return (s * 7 + 3) % 16;
  endfunction

  task automatic check(input bit ok, input string r, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (irq[0]) icnt0++;
      if (irq[1]) icnt1++;
      if (sample_hold) sh_run++;
      if (conv_start) begin
        obs.push_back(int'(mux_sel));
        check(sh_run == int'(acq_len) + 1, "R6", "sample window cycles",
              sh_run, int'(acq_len) + 1);
        sh_run = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        logic [3:0] m;
        m = mux_sel;
        repeat (lat) @(negedge clk);
        conv_done <= 1'b1;
        conv_data <= {m, tag};
        @(negedge clk);
        conv_done <= 1'b0;
      end
    end
  end

  task automatic fire(input logic [1:0] sw, input logic a, input logic b);
    @(negedge clk);
    sw_start = sw; ev_a = a; ev_b = b;
    @(negedge clk);
    sw_start = '0; ev_a = 1'b0; ev_b = 1'b0;
  endtask

  task automatic clear(input logic [1:0] c);
    @(negedge clk);
    seq_clear = c;
    @(negedge clk);
    seq_clear = '0;
  endtask

  task automatic wait_idle;
    repeat (2) @(negedge clk);
    while (busy != 2'b00) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_run(input int first, input int n, input int base,
                            input int wrap, input string r);
    for (int k = 0; k < n; k++) begin
      int sl, got, c;
      sl  = base + (first + k) % wrap;
      c   = chan(sl);
      got = (obs.size() > 0) ? obs.pop_front() : -1;
      check(got == c, r, "channel of slot", got, c);
      exp_res[sl] = 12'(c * 256 + int'(tag));
    end
  endtask

  task automatic no_more(input string r);
    check(obs.size() == 0, r, "extra conversions", obs.size(), 0);
    obs.delete();
  endtask

  task automatic check_results(input string r);
    for (int i = 0; i < 16; i++)
      check(results[i*12 +: 12] == exp_res[i], r, "result register",
            int'(results[i*12 +: 12]), int'(exp_res[i]));
  endtask

  initial begin
    int i0, i1;
    for (int s = 0; s < 16; s++) begin
      slot_chan[s*4 +: 4] = 4'(chan(s));
      exp_res[s] = '0;
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    check(busy == 0 && irq == 0 && ovf == 0, "R12", "flags after reset",
          int'({busy, irq, ovf}), 0);
    check(!conv_start && !sample_hold, "R12", "converter idle after reset",
          int'({conv_start, sample_hold}), 0);
    check_results("R12");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R5 R10: sequencer 1, every run length, alternating trigger source
    for (int m = 0; m < 8; m++) begin
      last_slot1 = 4'(m); tag = 8'(m + 1); i0 = icnt0;
      if (m % 2 == 0) fire(2'b01, 1'b0, 1'b0); else fire(2'b00, 1'b1, 1'b0);
      wait_idle();
      expect_run(0, m + 1, 0, 8, "R1");
      no_more("R3");
      check(icnt0 - i0 == 1, "R10", "irq per run seq1", icnt0 - i0, 1);
    end
    check_results("R5");

    // R1 R3: sequencer 2 driven by its own triggers
    for (int m = 0; m < 8; m++) begin
      last_slot2 = 3'(m); tag = 8'(m + 16); i1 = icnt1;
      if (m % 2 == 0) fire(2'b00, 1'b0, 1'b1); else fire(2'b10, 1'b0, 1'b0);
      wait_idle();
      expect_run(0, m + 1, 8, 8, "R3");
      no_more("R1");
      check(icnt1 - i1 == 1, "R10", "irq per run seq2", icnt1 - i1, 1);
    end
    check_results("R5");

    // R4 priority: both requested together
    last_slot1 = 4'd1; last_slot2 = 3'd1; tag = 8'h40;
    fire(2'b11, 1'b0, 1'b0);
    wait_idle();
    expect_run(0, 2, 0, 8, "R4");
    expect_run(0, 2, 8, 8, "R4");
    no_more("R4");

    // R2 cascade: every run length, ev_b now drives the single sequencer
    cascade = 1'b1;
    for (int m = 0; m < 16; m++) begin
      last_slot1 = 4'(m); tag = 8'(m + 64);
      case (m % 3)
        0: fire(2'b00, 1'b0, 1'b1);
        1: fire(2'b01, 1'b0, 1'b0);
        default: fire(2'b00, 1'b1, 1'b0);
      endcase
      wait_idle();
      expect_run(0, m + 1, 0, 16, "R2");
      no_more("R2");
    end
    check_results("R5");
    i1 = icnt1;
    fire(2'b10, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    check(busy == 0 && obs.size() == 0, "R2", "sw_start[1] ignored in cascade",
          int'(busy), 0);
    check(icnt1 == i1, "R2", "no seq2 irq in cascade", icnt1 - i1, 0);

    // R8 start/stop in cascade, wrap at 16, then R9 clear
    stop_start = 2'b01; last_slot1 = 4'd4;
    clear(2'b01);
    for (int r = 0; r < 4; r++) begin
      tag = 8'(r + 100);
      fire(2'b01, 1'b0, 1'b0);
      wait_idle();
      expect_run(r * 5, 5, 0, 16, "R8");
    end
    no_more("R8");
    check_results("R5");

    // R8 start/stop in dual mode, wrap at 8; R9 pointer reset
    cascade = 1'b0; last_slot1 = 4'd2;
    clear(2'b01);
    for (int r = 0; r < 3; r++) begin
      tag = 8'(r + 120);
      fire(2'b00, 1'b1, 1'b0);
      wait_idle();
      expect_run(r * 3, 3, 0, 8, "R8");
    end
    clear(2'b01);
    fire(2'b01, 1'b0, 1'b0);
    wait_idle();
    expect_run(0, 3, 0, 8, "R9");
    no_more("R9");

    // R7 continuous: every run starts at slot 0
    stop_start = 2'b00; last_slot1 = 4'd1;
    clear(2'b01);
    for (int r = 0; r < 2; r++) begin
      fire(2'b01, 1'b0, 1'b0);
      wait_idle();
      expect_run(0, 2, 0, 8, "R7");
    end
    no_more("R7");

    // R10 interrupt on every second end of sequence
    irq_alt = 2'b01; last_slot1 = 4'd0;
    clear(2'b01);
    for (int r = 0; r < 4; r++) begin
      i0 = icnt0;
      fire(2'b01, 1'b0, 1'b0);
      wait_idle();
      check(icnt0 - i0 == (r % 2), "R10", "alternate irq", icnt0 - i0, r % 2);
    end
    irq_alt = 2'b00;
    obs.delete();

    // R11 pending and overflow
    last_slot1 = 4'd7; acq_len = 4'd3; tag = 8'hA5;
    clear(2'b01);
    fire(2'b00, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    fire(2'b00, 1'b1, 1'b0);
    check(ovf == 2'b00, "R11", "one pending request no overflow", int'(ovf), 0);
    fire(2'b01, 1'b0, 1'b0);
    check(ovf == 2'b01, "R11", "second trigger sets overflow", int'(ovf), 1);
    wait_idle();
    expect_run(0, 8, 0, 8, "R11");
    expect_run(0, 8, 0, 8, "R11");
    no_more("R11");
    check(ovf == 2'b01, "R11", "overflow sticky", int'(ovf), 1);
    clear(2'b01);
    check(ovf == 2'b00, "R9", "clear drops overflow", int'(ovf), 0);

    // R6 sweep of every window length and several converter latencies
    last_slot1 = 4'd0;
    for (int l = 0; l < 16; l++) begin
      acq_len = 4'(l); lat = l % 4 + 1; tag = 8'(l + 200);
      fire(2'b01, 1'b0, 1'b0);
      wait_idle();
      expect_run(0, 1, 0, 8, "R6");
    end
    no_more("R6");
    check_results("R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule